// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral request lines and a processor core. Every source owns a sticky pending flag. Several sources share each vector, and each vector carries a programmable priority and subpriority. Each cycle the block chooses one winner among the flagged and enabled requests. The core receives a registered request line, a vector number, the winning priority level, a register-set number and a vector entry address.

Software programs the block through a single write port. A write carries a kind code on `wr_kind`, an index and a data word. A few external pins feed the lowest-numbered sources through edge detectors with selectable polarity.

Top module: `pvic_top`

## Requirements
- R1: Source s belongs to vector s mod N_VEC, so with defaults sources 5 and 69 both raise vector 5; a pending, enabled source makes its vector eligible.
- R2: A vector whose priority field is 0 never wins and never raises `irq_out`. The priority is written with kind 3, index = vector, data[2:0] = priority, data[4:3] = subpriority.
- R3: Among eligible vectors the higher priority wins. At equal priority the higher subpriority wins.
- R4: When priority and subpriority are both equal, the lower-numbered vector wins.
- R5: Kind 4 writes the control word: data[0] = 1 selects multi-vector mode, which outputs the winner's number on `vec_out`. data[0] = 0 selects single-vector mode, which outputs vector 0. data[N_EXT:1] hold the per-pin polarities.
- R6: When the winner's priority is 7, `set_out` equals SHADOW_SET (default 1). At any other priority, and when there is no winner, `set_out` is 0.
- R7: A write of kind 1 to a source index sets that source's flag. The flag then behaves exactly like one raised by `src_req`.
- R8: External pin i sets the flag of source i. A polarity bit of 1 selects a rising edge and 0 selects a falling edge. An edge of the unselected direction sets nothing.
- R9: `vec_addr` equals base + `vec_out` × spacing. Kind 5 writes the base and kind 6 writes the spacing, each from the full data word. When there is no winner, `vec_addr` equals base.
- R10: Kind 0 writes a source's enable from data[0]. A flagged source that is not enabled takes no part in arbitration, but its flag stays visible.
- R11: `irq_out` is 1 only when a winner exists and its priority is strictly greater than `core_prio`. `lvl_out` shows the winner's priority either way.
- R12: Flags update on the clock edge that samples the event. The core-side outputs reflect the flags one clock edge later.
- R13: Flags are sticky. A write of kind 2 with data[0] = 1 clears the indexed flag, and a kind 2 write with data[0] = 0 leaves it set.
- R14: Reset clears every flag, enable, priority and output. It also selects single-vector mode, base 0, spacing 0x20 and rising polarity on all pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Hardware request pulses, one per source |
| ext_pin | input | N_EXT | External interrupt pins, routed to sources 0..N_EXT-1 |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 3 | Write kind code |
| wr_idx | input | IDX_W | Source or vector index of the write |
| wr_data | input | 32 | Write data |
| core_prio | input | 3 | Current priority of the core |
| irq_out | output | 1 | Request presented to the core |
| vec_out | output | VEC_W | Vector number |
| lvl_out | output | 3 | Priority of the winner |
| set_out | output | SET_W | Register set number for the core |
| vec_addr | output | 32 | Vector entry address |
| flags_out | output | N_SRC | Pending flags |

## Verification
The bench targets the tie cases of arbitration. It pits a higher subpriority against equal priority, and two identical vectors against each other. A design that compares only priority, or that scans in the wrong direction, would report the wrong vector number. A vector with priority 0 and a source that is flagged but not enabled are both raised, and a design that forgets either gate would assert `irq_out`. The bench also checks that a shared vector answers to a high-numbered source and that a clear write with data 0 leaves the flag set. It checks that an edge of the wrong polarity is ignored, and that a request at exactly the core's priority stays masked, which catches a ≥ used in place of >.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int PRIO_W = 3;
    localparam int SUB_W  = 2;
    localparam int RANK_W = PRIO_W + SUB_W;
    localparam logic [PRIO_W-1:0] PRIO_TOP = 3'd7;

    typedef enum logic [2:0] {
        WR_ENABLE = 3'd0,
        WR_SET    = 3'd1,
        WR_CLEAR  = 3'd2,
        WR_LEVEL  = 3'd3,
        WR_CTRL   = 3'd4,
        WR_BASE   = 3'd5,
        WR_SPACE  = 3'd6
    } wr_kind_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [SUB_W-1:0]  sub;
    } vec_cfg_t;

    function automatic logic [RANK_W-1:0] rank_of(vec_cfg_t c);
        return {c.prio, c.sub};
    endfunction

    function automatic int home_vec(int src, int n_vec);
        return src % n_vec;
    endfunction

endpackage

// File: rtl/pvic_edge.sv
module pvic_edge #(
    parameter int N_EXT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] pol,
    output logic [N_EXT-1:0] hit
);

    logic [N_EXT-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin;
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        // polarity 1: low-to-high, polarity 0: high-to-low
        assign hit[i] = pol[i] ? (pin[i] & ~prev_q[i]) : (~pin[i] & prev_q[i]);
    end

endmodule

// File: rtl/pvic_flags.sv
module pvic_flags #(
    parameter int N_SRC = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] flags
);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= set | (flags & ~clr);
    end

    // R13: a flag only drops when a clear was requested for it
    p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(flags) & ~$past(clr)) & ~flags) == '0));

    // R7: any set request leaves the flag raised on the next edge
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(set) & ~flags) == '0));

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
    import pvic_pkg::*;
#(
    parameter int N_VEC = 64,
    parameter int VEC_W = $clog2(N_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_VEC-1:0] pend,
    input  vec_cfg_t         cfg [N_VEC],
    output logic             win_valid,
    output logic [VEC_W-1:0] win_idx,
    output vec_cfg_t         win_cfg
);

    // Ascending scan, replace only on a strictly larger rank:
    // equal ranks keep the lower vector number.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_cfg   = '0;
        for (int v = 0; v < N_VEC; v++) begin
            if (pend[v] && cfg[v].prio != '0 &&
                (!win_valid || rank_of(cfg[v]) > rank_of(win_cfg))) begin
                win_valid = 1'b1;
                win_idx   = VEC_W'(v);
                win_cfg   = cfg[v];
            end
        end
    end

    // R2: a winner is always pending and never at priority 0
    p_winner_live_r2: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (pend[win_idx] && cfg[win_idx].prio != '0));

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int N_SRC      = 96,
    parameter int N_VEC      = 64,
    parameter int N_EXT      = 5,
    parameter int SET_W      = 3,
    parameter int SHADOW_SET = 1,
    parameter int IDX_W      = $clog2(N_SRC),
    parameter int VEC_W      = $clog2(N_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic             wr_en,
    input  logic [2:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       core_prio,
    output logic             irq_out,
    output logic [VEC_W-1:0] vec_out,
    output logic [2:0]       lvl_out,
    output logic [SET_W-1:0] set_out,
    output logic [31:0]      vec_addr,
    output logic [N_SRC-1:0] flags_out
);

    localparam logic [31:0] SPACE_RST = 32'h20;

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    // ---------------- configuration state ----------------
    logic [N_SRC-1:0] en_q;
    vec_cfg_t         cfg_q [N_VEC];
    logic             multi_q;
    logic [N_EXT-1:0] pol_q;
    logic [31:0]      base_q;
    logic [31:0]      space_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            for (int v = 0; v < N_VEC; v++) cfg_q[v] <= '0;
            multi_q <= 1'b0;
            pol_q   <= '1;
            base_q  <= '0;
            space_q <= SPACE_RST;
        end else if (wr_en) begin
            case (kind)
                WR_ENABLE: if (int'(wr_idx) < N_SRC) en_q[wr_idx] <= wr_data[0];
                WR_LEVEL:  if (int'(wr_idx) < N_VEC)
                               cfg_q[wr_idx[VEC_W-1:0]] <= '{prio: wr_data[2:0], sub: wr_data[4:3]};
                WR_CTRL: begin
                    multi_q <= wr_data[0];
                    pol_q   <= wr_data[N_EXT:1];
                end
                WR_BASE:   base_q  <= wr_data;
                WR_SPACE:  space_q <= wr_data;
                default: ;
            endcase
        end
    end

    // ---------------- flag set / clear decode ----------------
    logic [N_EXT-1:0] ext_hit;
    logic [N_SRC-1:0] ext_set, sw_set, sw_clr, set_all, flags;

    pvic_edge #(.N_EXT(N_EXT)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .pol (pol_q),
        .hit (ext_hit)
    );

    always_comb begin
        ext_set = '0;
        ext_set[N_EXT-1:0] = ext_hit;
        for (int s = 0; s < N_SRC; s++) begin
            sw_set[s] = wr_en && kind == WR_SET   && int'(wr_idx) == s;
            sw_clr[s] = wr_en && kind == WR_CLEAR && int'(wr_idx) == s && wr_data[0];
        end
    end

    assign set_all = src_req | sw_set | ext_set;

    pvic_flags #(.N_SRC(N_SRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set_all),
        .clr   (sw_clr),
        .flags (flags)
    );

    assign flags_out = flags;

    // ---------------- source to vector folding ----------------
    logic [N_VEC-1:0] pend;

    always_comb begin
        pend = '0;
        for (int s = 0; s < N_SRC; s++)
            if (flags[s] && en_q[s]) pend[home_vec(s, N_VEC)] = 1'b1;
    end

    logic             win_valid;
    logic [VEC_W-1:0] win_idx;
    vec_cfg_t         win_cfg;

    pvic_arb #(.N_VEC(N_VEC), .VEC_W(VEC_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .cfg       (cfg_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_cfg   (win_cfg)
    );

    // ---------------- registered core-side outputs ----------------
    logic [VEC_W-1:0] vec_sel;
    assign vec_sel = multi_q ? win_idx : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out  <= 1'b0;
            vec_out  <= '0;
            lvl_out  <= '0;
            set_out  <= '0;
            vec_addr <= '0;
        end else begin
            irq_out <= win_valid && (win_cfg.prio > core_prio);
            if (win_valid) begin
                vec_out  <= vec_sel;
                lvl_out  <= win_cfg.prio;
                set_out  <= (win_cfg.prio == PRIO_TOP) ? SET_W'(SHADOW_SET) : '0;
                vec_addr <= base_q + 32'(vec_sel) * space_q;
            end else begin
                vec_out  <= '0;
                lvl_out  <= '0;
                set_out  <= '0;
                vec_addr <= base_q;
            end
        end
    end

    // R11: the core is only interrupted above its own level
    p_above_core_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && irq_out |-> lvl_out > $past(core_prio));

    // R5: single-vector mode always reports the common vector
    p_single_vec_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(multi_q) |-> vec_out == '0);

    // R9: address tracks the reported vector number
    p_addr_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> vec_addr == $past(base_q) + 32'(vec_out) * $past(space_q));

endmodule

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
    import pvic_pkg::*;

    localparam int CLK_P = 10;
    localparam int N_SRC = 96;
    localparam int N_EXT = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_SRC-1:0] src_req = '0;
    logic [N_EXT-1:0] ext_pin = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_kind = '0;
    logic [6:0]       wr_idx = '0;
    logic [31:0]      wr_data = '0;
    logic [2:0]       core_prio = '0;
    logic             irq_out;
    logic [5:0]       vec_out;
    logic [2:0]       lvl_out;
    logic [2:0]       set_out;
    logic [31:0]      vec_addr;
    logic [N_SRC-1:0] flags_out;

    pvic_top u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .core_prio(core_prio), .irq_out(irq_out), .vec_out(vec_out),
        .lvl_out(lvl_out), .set_out(set_out), .vec_addr(vec_addr),
        .flags_out(flags_out)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        string       tag;
        bit          full;
        bit          irq;
        int          vec;
        int          lvl;
        int          sh;
        logic [31:0] addr;
        int          fidx;
        bit          fexp;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares one expected item just after each rising edge
    initial forever begin
        @(posedge clk);
        #(CLK_P/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " irq"}, 32'(irq_out), 32'(e.irq));
            if (e.full) begin
                check({e.tag, " vec"},  32'(vec_out), e.vec);
                check({e.tag, " lvl"},  32'(lvl_out), e.lvl);
                check({e.tag, " set"},  32'(set_out), e.sh);
                check({e.tag, " addr"}, vec_addr, e.addr);
            end
            if (e.fidx >= 0)
                check({e.tag, " flag"}, 32'(flags_out[e.fidx]), 32'(e.fexp));
        end
    end

    task automatic push_full(string tag, bit irq, int vec, int lvl, int sh,
                             logic [31:0] addr, int fidx, bit fexp);
        exp_t e;
        e.tag = tag; e.full = 1; e.irq = irq; e.vec = vec; e.lvl = lvl;
        e.sh = sh; e.addr = addr; e.fidx = fidx; e.fexp = fexp;
        q.push_back(e);
    endtask

    task automatic push_flag(string tag, bit irq, int fidx, bit fexp);
        exp_t e;
        e.tag = tag; e.full = 0; e.irq = irq; e.vec = 0; e.lvl = 0;
        e.sh = 0; e.addr = '0; e.fidx = fidx; e.fexp = fexp;
        q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(wr_kind_e k, int idx, logic [31:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; src_req = '0; ext_pin = '0; wr_en = 1'b0; core_prio = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic pulse(int s);
        src_req[s] = 1'b1;
        tick();
        src_req[s] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick();
        do_reset();
        // R14: reset state
        push_full("R14 reset", 0, 0, 0, 0, 32'h0, 0, 0);
        tick();

        // R1/R9/R12: source 69 lands on vector 5
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_BASE, 0, 32'h1000);
        wr(WR_SPACE, 0, 32'h20);
        wr(WR_LEVEL, 5, 32'h3);
        wr(WR_ENABLE, 69, 32'h1);
        src_req[69] = 1'b1;
        push_flag("R12 flag first", 0, 69, 1);
        tick();
        src_req[69] = 1'b0;
        push_full("R1 R9 shared vector", 1, 5, 3, 0, 32'h10A0, 69, 1);
        tick();

        // R13: clear write with data 0 keeps flag, data 1 clears
        push_flag("R13 clear data0", 1, 69, 1);
        wr(WR_CLEAR, 69, 32'h0);
        push_flag("R13 clear data1", 1, 69, 0);
        wr(WR_CLEAR, 69, 32'h1);
        push_flag("R13 after clear", 0, 69, 0);
        tick();

        // R2: priority 0 vector never presented
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 7, 32'h0);
        wr(WR_ENABLE, 7, 32'h1);
        pulse(7);
        push_flag("R2 prio zero", 0, 7, 1);
        tick();

        // R3: priority then subpriority
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_BASE, 0, 32'h2000);
        wr(WR_SPACE, 0, 32'h10);
        wr(WR_LEVEL, 10, 32'h04);
        wr(WR_LEVEL, 12, 32'h1C);
        wr(WR_LEVEL, 11, 32'h02);
        wr(WR_ENABLE, 10, 32'h1);
        wr(WR_ENABLE, 11, 32'h1);
        wr(WR_ENABLE, 12, 32'h1);
        src_req[12:10] = 3'b111;
        tick();
        src_req[12:10] = 3'b000;
        push_full("R3 subprio wins", 1, 12, 4, 0, 32'h20C0, 12, 1);
        tick();
        wr(WR_CLEAR, 12, 32'h1);
        push_full("R3 next by subprio", 1, 10, 4, 0, 32'h20A0, 12, 0);
        tick();
        wr(WR_CLEAR, 10, 32'h1);
        push_full("R3 lower prio last", 1, 11, 2, 0, 32'h20B0, 10, 0);
        tick();

        // R4: full tie, lower vector wins
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 20, 32'h0D);
        wr(WR_LEVEL, 21, 32'h0D);
        wr(WR_ENABLE, 20, 32'h1);
        wr(WR_ENABLE, 21, 32'h1);
        src_req[21:20] = 2'b11;
        tick();
        src_req[21:20] = 2'b00;
        push_full("R4 tie lower wins", 1, 20, 5, 0, 32'h280, 21, 1);
        tick();

        // R5: single-vector mode
        wr(WR_CTRL, 0, 32'h3E);
        push_full("R5 single vector", 1, 0, 5, 0, 32'h0, -1, 0);
        tick();

        // R6: top priority selects shadow set
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 30, 32'h7);
        wr(WR_ENABLE, 30, 32'h1);
        pulse(30);
        push_full("R6 shadow set", 1, 30, 7, 1, 32'h3C0, 30, 1);
        tick();

        // R7: software-raised request
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 40, 32'h2);
        wr(WR_ENABLE, 40, 32'h1);
        wr(WR_SET, 40, 32'h0);
        push_full("R7 software set", 1, 40, 2, 0, 32'h500, 40, 1);
        tick();

        // R8: edge polarity on external pins (pin 1 falling)
        do_reset();
        wr(WR_CTRL, 0, 32'h3B);
        ext_pin[1] = 1'b1;
        push_flag("R8 wrong edge ignored", 0, 1, 0);
        tick();
        ext_pin[1] = 1'b0;
        push_flag("R8 falling edge", 0, 1, 1);
        tick();
        ext_pin[2] = 1'b1;
        push_flag("R8 rising edge", 0, 2, 1);
        tick();
        ext_pin[2] = 1'b0;
        tick();

        // R10: enable gating
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 50, 32'h6);
        pulse(50);
        push_flag("R10 disabled source", 0, 50, 1);
        tick();
        wr(WR_ENABLE, 50, 32'h1);
        push_full("R10 enabled later", 1, 50, 6, 0, 32'h640, 50, 1);
        tick();

        // R11: strict comparison with core priority
        do_reset();
        wr(WR_CTRL, 0, 32'h3F);
        wr(WR_LEVEL, 3, 32'h4);
        wr(WR_ENABLE, 3, 32'h1);
        core_prio = 3'd4;
        pulse(3);
        push_flag("R11 equal level masked", 0, 3, 1);
        tick();
        core_prio = 3'd3;
        push_full("R11 above core", 1, 3, 4, 0, 32'h60, 3, 1);
        tick();

        tick(); tick();
        finish_run();
    end

endmodule